// File: doc/BRIEF.md
# Traffic Class to Virtual Channel Steering

This block sits at the transmit side of a link port and picks, for every packet header it is handed, the virtual channel queue that will carry it. Each virtual channel owns an 8-bit class map: bit i set means that traffic class i travels on that channel. Software programs these maps through a small write/read port. Each write is checked before it is committed, so the maps always form a legal partition of the eight classes over the enabled channels. Class 0 is pinned to channel 0 and cannot be moved.

The number of usable channels is taken from two 3-bit extended-count fields: one for the local port and one for the link partner. The smaller of the two, plus one, is the number of enabled channels. Channel 0 is always among them.

A header arrives on a valid/ready input with a 3-bit class and a 2-bit transaction type. Headers that break the class-0 rule for maintenance traffic are dropped and flagged. So are headers whose class has no enabled channel. Every other header is written into a one-deep holding slot for its channel and leaves on that channel's valid/ready output with its class and type unchanged.

Top module: `class_lane_steer`

## Requirements
- R1: An accepted legal header appears on exactly one channel output, the enabled channel whose map has the bit for its class set. Its class and type are copied unchanged, and its valid goes high one clock after the accepting edge.
- R2: A write to the map of channel `cfgWrAddr` commits `cfgWrData` at the clock edge. `cfgRdData` combinationally returns the map of channel `cfgRdAddr`, with bit i standing for class i.
- R3: Bit 0 of channel 0's map always reads 1, and a write that clears it has no effect on that bit. A write that sets bit 0 on any other channel is rejected.
- R4: A write that sets a class bit already held by a different channel is rejected and the old map is kept. Every rejected write raises `cfgErr` for exactly one cycle, one clock after the write.
- R5: One channel may hold several classes, and headers of each of those classes are steered to it.
- R6: The enabled channels are 0 through min(`localMaxCnt`, `peerMaxCnt`). A disabled channel's map is cleared and is never used for steering, and writes to a disabled channel are rejected.
- R7: The type encoding is 0 memory, 1 configuration, 2 I/O and 3 message. A header of type 1, 2 or 3 with a nonzero class is consumed without output, and `malformedErr` pulses for one cycle one clock later.
- R8: A legal header whose class is held by no enabled channel is consumed without output, and `unmappedErr` pulses for one cycle one clock later.
- R9: After reset, channel 0's map is 0x01, every other map is 0x00, all output valids are low and all error outputs are low.
- R10: A steerable header is accepted only when its channel's slot is empty or being drained in the same cycle. A stalled slot keeps its item unchanged and does not block headers bound for other channels. Dropped headers are always accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| localMaxCnt | input | 3 | Local extended channel count |
| peerMaxCnt | input | 3 | Link-partner extended channel count |
| cfgWrEn | input | 1 | Map write strobe |
| cfgWrAddr | input | 3 | Channel whose map is written |
| cfgWrData | input | 8 | New class map |
| cfgRdAddr | input | 3 | Channel whose map is read |
| cfgRdData | output | 8 | Class map of the read channel |
| cfgErr | output | 1 | Rejected-write pulse |
| hdrValid | input | 1 | Header valid |
| hdrReady | output | 1 | Header accepted this cycle |
| hdrClass | input | 3 | Traffic class of the header |
| hdrType | input | 2 | Transaction type of the header |
| outValid | output | 8 | Per-channel output valid |
| outReady | input | 8 | Per-channel output ready |
| outClass | output | 24 | Per-channel class, 3 bits per channel |
| outType | output | 16 | Per-channel type, 2 bits per channel |
| malformedErr | output | 1 | Illegal class-for-type pulse |
| unmappedErr | output | 1 | Unmapped-class pulse |

## Verification
Every result of this block is due one clock after the edge that takes in its stimulus: a channel valid, one of the three error pulses, or a committed map. Map readback is combinational and is sampled shortly after the address is driven. The driver applies stimulus on the falling edge and records the expected result. The monitor samples each falling edge and retires one expected item for every output valid it sees together with ready and for every error pulse. A pulse that lingers, or an output on the wrong channel, therefore shows up as an unexpected item. For stalled channels, the monitor matches on kind and channel rather than strict arrival order.

// File: rtl/class_steer_pkg.sv
package class_steer_pkg;
  localparam int CLS_W    = 3;
  localparam int MAP_W    = 1 << CLS_W;
  localparam int CH_IDX_W = 3;
  localparam int TYPE_W   = 2;

  typedef enum logic [TYPE_W-1:0] {
    TT_MEM = 2'd0,
    TT_CFG = 2'd1,
    TT_IO  = 2'd2,
    TT_MSG = 2'd3
  } txnType_e;

  typedef struct packed {
    logic                wrEn;
    logic [CH_IDX_W-1:0] wrChan;
    logic [MAP_W-1:0]    wrData;
    logic                push;
    logic [CH_IDX_W-1:0] pushChan;
  } ctrlStb_t;
endpackage

// File: rtl/class_steer_path.sv
module class_steer_path
  import class_steer_pkg::*;
#(
  parameter int NumChan = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStb_t                    stb,
  input  logic [CH_IDX_W-1:0]         localMaxCnt,
  input  logic [CH_IDX_W-1:0]         peerMaxCnt,
  input  logic [CLS_W-1:0]            hdrClass,
  input  logic [TYPE_W-1:0]           hdrType,
  input  logic [NumChan-1:0]          outReady,
  input  logic [CH_IDX_W-1:0]         rdAddr,
  output logic [MAP_W-1:0]            rdData,
  output logic [NumChan*MAP_W-1:0]    mapFlat,
  output logic [NumChan-1:0]          enMask,
  output logic                        hit,
  output logic [CH_IDX_W-1:0]         selIdx,
  output logic [NumChan-1:0]          slotFree,
  output logic [NumChan-1:0]          outValid,
  output logic [NumChan*CLS_W-1:0]    outClass,
  output logic [NumChan*TYPE_W-1:0]   outType
);
  logic [MAP_W-1:0]  mapQ    [NumChan];
  logic [CLS_W-1:0]  slotCls [NumChan];
  logic [TYPE_W-1:0] slotTyp [NumChan];
  logic [NumChan-1:0] hitVec;
  logic [CH_IDX_W-1:0] minCnt;

  assign minCnt = (localMaxCnt < peerMaxCnt) ? localMaxCnt : peerMaxCnt;

  for (genvar c = 0; c < NumChan; c++) begin : g_chan
    assign enMask[c] = (CH_IDX_W'(c) <= minCnt);
    assign hitVec[c] = enMask[c] & mapQ[c][hdrClass];
    assign mapFlat[c*MAP_W +: MAP_W] = mapQ[c];
    assign slotFree[c] = !outValid[c] || outReady[c];
    assign outClass[c*CLS_W +: CLS_W] = slotCls[c];
    assign outType[c*TYPE_W +: TYPE_W] = slotTyp[c];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        mapQ[c] <= (c == 0) ? MAP_W'(1) : '0;
      end else if (!enMask[c]) begin
        mapQ[c] <= '0;
      end else if (stb.wrEn && stb.wrChan == CH_IDX_W'(c)) begin
        mapQ[c] <= stb.wrData;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        outValid[c] <= 1'b0;
        slotCls[c]  <= '0;
        slotTyp[c]  <= '0;
      end else if (stb.push && stb.pushChan == CH_IDX_W'(c)) begin
        outValid[c] <= 1'b1;
        slotCls[c]  <= hdrClass;
        slotTyp[c]  <= hdrType;
      end else if (outReady[c]) begin
        outValid[c] <= 1'b0;
      end
    end

    // R10
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (outValid[c] && !outReady[c]) |=> (outValid[c] && $stable(slotCls[c]) && $stable(slotTyp[c])));
  end

  assign hit = |hitVec;

  always_comb begin
    selIdx = '0;
    for (int c = 0; c < NumChan; c++) begin
      if (hitVec[c]) selIdx = CH_IDX_W'(c);
    end
  end

  always_comb begin
    rdData = '0;
    for (int c = 0; c < NumChan; c++) begin
      if (rdAddr == CH_IDX_W'(c)) rdData = mapQ[c];
    end
  end

  // R3
  chan0_default_chk: assert property (@(posedge clk) disable iff (!rstN) mapQ[0][0]);

  for (genvar b = 0; b < MAP_W; b++) begin : g_excl
    logic [NumChan-1:0] colVec;
    for (genvar c = 0; c < NumChan; c++) begin : g_col
      assign colVec[c] = mapQ[c][b];
    end
    // R4
    class_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
      $countones(colVec) <= 1);
  end

  // R1 R7
  push_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.push |-> (mapQ[stb.pushChan][hdrClass] && enMask[stb.pushChan]
                  && (hdrType == TT_MEM || hdrClass == '0)));
endmodule

// File: rtl/class_steer_ctrl.sv
module class_steer_ctrl
  import class_steer_pkg::*;
#(
  parameter int NumChan = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cfgWrEn,
  input  logic [CH_IDX_W-1:0]      cfgWrAddr,
  input  logic [MAP_W-1:0]         cfgWrData,
  input  logic [NumChan*MAP_W-1:0] mapFlat,
  input  logic [NumChan-1:0]       enMask,
  input  logic                     hdrValid,
  input  logic [CLS_W-1:0]         hdrClass,
  input  logic [TYPE_W-1:0]        hdrType,
  input  logic                     hit,
  input  logic [CH_IDX_W-1:0]      selIdx,
  input  logic [NumChan-1:0]       slotFree,
  output ctrlStb_t                 stb,
  output logic                     hdrReady,
  output logic                     cfgErr,
  output logic                     malformedErr,
  output logic                     unmappedErr
);
  logic [MAP_W-1:0] ownedOthers;
  logic [MAP_W-1:0] dataFix;
  logic addrOk, badZero, conflict, reject;
  logic malformed, accept;

  always_comb begin
    ownedOthers = '0;
    addrOk = 1'b0;
    for (int c = 0; c < NumChan; c++) begin
      if (cfgWrAddr == CH_IDX_W'(c)) addrOk = enMask[c];
      else ownedOthers = ownedOthers | mapFlat[c*MAP_W +: MAP_W];
    end
  end

  assign dataFix  = (cfgWrAddr == '0) ? (cfgWrData | MAP_W'(1)) : cfgWrData;
  assign badZero  = (cfgWrAddr != '0) && cfgWrData[0];
  assign conflict = |(dataFix & ownedOthers);
  assign reject   = cfgWrEn && (!addrOk || badZero || conflict);

  assign malformed = (hdrType != TT_MEM) && (hdrClass != '0);
  assign hdrReady  = malformed || !hit || slotFree[selIdx];
  assign accept    = hdrValid && hdrReady;

  always_comb begin
    stb          = '0;
    stb.wrEn     = cfgWrEn && !reject;
    stb.wrChan   = cfgWrAddr;
    stb.wrData   = dataFix;
    stb.push     = accept && !malformed && hit;
    stb.pushChan = selIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgErr       <= 1'b0;
      malformedErr <= 1'b0;
      unmappedErr  <= 1'b0;
    end else begin
      cfgErr       <= reject;
      malformedErr <= accept && malformed;
      unmappedErr  <= accept && !malformed && !hit;
    end
  end

  // R4
  reject_no_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && conflict) |-> !stb.wrEn);

  // R7 R8
  drop_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(malformedErr && unmappedErr));
endmodule

// File: rtl/class_lane_steer.sv
module class_lane_steer
  import class_steer_pkg::*;
#(
  parameter int NumChan = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [CH_IDX_W-1:0]        localMaxCnt,
  input  logic [CH_IDX_W-1:0]        peerMaxCnt,
  input  logic                       cfgWrEn,
  input  logic [CH_IDX_W-1:0]        cfgWrAddr,
  input  logic [MAP_W-1:0]           cfgWrData,
  input  logic [CH_IDX_W-1:0]        cfgRdAddr,
  output logic [MAP_W-1:0]           cfgRdData,
  output logic                       cfgErr,
  input  logic                       hdrValid,
  output logic                       hdrReady,
  input  logic [CLS_W-1:0]           hdrClass,
  input  logic [TYPE_W-1:0]          hdrType,
  output logic [NumChan-1:0]         outValid,
  input  logic [NumChan-1:0]         outReady,
  output logic [NumChan*CLS_W-1:0]   outClass,
  output logic [NumChan*TYPE_W-1:0]  outType,
  output logic                       malformedErr,
  output logic                       unmappedErr
);
  ctrlStb_t stb;
  logic [NumChan*MAP_W-1:0] mapFlat;
  logic [NumChan-1:0] enMask, slotFree;
  logic hit;
  logic [CH_IDX_W-1:0] selIdx;

  class_steer_ctrl #(.NumChan(NumChan)) uCtrl (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgWrAddr(cfgWrAddr), .cfgWrData(cfgWrData),
    .mapFlat(mapFlat), .enMask(enMask),
    .hdrValid(hdrValid), .hdrClass(hdrClass), .hdrType(hdrType),
    .hit(hit), .selIdx(selIdx), .slotFree(slotFree),
    .stb(stb), .hdrReady(hdrReady),
    .cfgErr(cfgErr), .malformedErr(malformedErr), .unmappedErr(unmappedErr)
  );

  class_steer_path #(.NumChan(NumChan)) uPath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .localMaxCnt(localMaxCnt), .peerMaxCnt(peerMaxCnt),
    .hdrClass(hdrClass), .hdrType(hdrType), .outReady(outReady),
    .rdAddr(cfgRdAddr), .rdData(cfgRdData),
    .mapFlat(mapFlat), .enMask(enMask), .hit(hit), .selIdx(selIdx),
    .slotFree(slotFree), .outValid(outValid),
    .outClass(outClass), .outType(outType)
  );
endmodule

// File: tb/tb_class_lane_steer.sv
module tb_class_lane_steer;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] localMaxCnt = 3'd3, peerMaxCnt = 3'd2;
  logic cfgWrEn = 1'b0;
  logic [2:0] cfgWrAddr = '0, cfgRdAddr = '0;
  logic [7:0] cfgWrData = '0, cfgRdData;
  logic cfgErr, hdrValid = 1'b0, hdrReady;
  logic [2:0] hdrClass = '0;
  logic [1:0] hdrType = '0;
  logic [NCH-1:0] outValid, outReady = '1;
  logic [NCH*3-1:0] outClass;
  logic [NCH*2-1:0] outType;
  logic malformedErr, unmappedErr;

  int compared = 0, mismatched = 0;
  bit running = 1'b0, done = 1'b0;
  // item = {kind[1:0], chan[2:0], type[1:0], class[2:0]}; kind 0 data, 1 cfg, 2 malformed, 3 unmapped
  logic [9:0] expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  class_lane_steer dut (
    .clk(clk), .rstN(rstN), .localMaxCnt(localMaxCnt), .peerMaxCnt(peerMaxCnt),
    .cfgWrEn(cfgWrEn), .cfgWrAddr(cfgWrAddr), .cfgWrData(cfgWrData),
    .cfgRdAddr(cfgRdAddr), .cfgRdData(cfgRdData), .cfgErr(cfgErr),
    .hdrValid(hdrValid), .hdrReady(hdrReady), .hdrClass(hdrClass), .hdrType(hdrType),
    .outValid(outValid), .outReady(outReady), .outClass(outClass), .outType(outType),
    .malformedErr(malformedErr), .unmappedErr(unmappedErr)
  );

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic retire(input logic [1:0] kind, input logic [2:0] chan,
                        input logic [1:0] typ, input logic [2:0] cls);
    int idx = -1;
    for (int i = 0; i < expQ.size(); i++) begin
      if (idx < 0 && expQ[i][9:8] == kind && expQ[i][7:5] == chan) idx = i;
    end
    compared++;
    if (idx < 0) begin
      mismatched++;
      $display("FAIL R1/R4/R7/R8 unexpected item actual=0x%0h expected=none", {kind, chan, typ, cls});
    end else begin
      if (expQ[idx][4:0] != {typ, cls}) begin
        mismatched++;
        $display("FAIL R1 passthrough actual=0x%0h expected=0x%0h", {typ, cls}, expQ[idx][4:0]);
      end
      expQ.delete(idx);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      for (int c = 0; c < NCH; c++)
        if (outValid[c] && outReady[c])
          retire(2'd0, 3'(c), outType[c*2 +: 2], outClass[c*3 +: 3]);
      if (cfgErr)       retire(2'd1, 3'd0, 2'd0, 3'd0);
      if (malformedErr) retire(2'd2, 3'd0, 2'd0, 3'd0);
      if (unmappedErr)  retire(2'd3, 3'd0, 2'd0, 3'd0);
    end
  end

  task automatic wrCfg(input logic [2:0] ch, input logic [7:0] data, input bit expErr);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrAddr = ch; cfgWrData = data;
    if (expErr) expQ.push_back({2'd1, 3'd0, 5'd0});
    @(posedge clk); #1;
    cfgWrEn = 1'b0;
  endtask

  task automatic rdMap(input string tag, input logic [2:0] ch, input logic [7:0] exp);
    @(negedge clk);
    cfgRdAddr = ch; #1;
    check(tag, cfgRdData, exp);
  endtask

  // kind 0: expect channel chan; kind 2/3: expect drop with error
  task automatic sendHdr(input string tag, input logic [2:0] cls, input logic [1:0] typ,
                         input logic [1:0] kind, input logic [2:0] chan);
    @(negedge clk);
    hdrValid = 1'b1; hdrClass = cls; hdrType = typ; #1;
    check({tag, " ready"}, hdrReady, 1);
    if (kind == 2'd0) expQ.push_back({2'd0, chan, typ, cls});
    else expQ.push_back({kind, 3'd0, 5'd0});
    @(posedge clk); #1;
    hdrValid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    running = 1'b1;
    // R9 reset state
    @(negedge clk);
    check("R9 outValid", outValid, 0);
    check("R9 errors", {cfgErr, malformedErr, unmappedErr}, 0);
    rdMap("R9 ch0 map", 3'd0, 8'h01);
    rdMap("R9 ch1 map", 3'd1, 8'h00);
    sendHdr("R3 class0 to ch0", 3'd0, 2'd0, 2'd0, 3'd0);
    // R3 clearing ch0 bit0 has no effect
    wrCfg(3'd0, 8'h00, 1'b0);
    rdMap("R3 ch0 keeps bit0", 3'd0, 8'h01);
    // R2 plain write/readback
    wrCfg(3'd1, 8'h06, 1'b0);
    rdMap("R2 ch1 map", 3'd1, 8'h06);
    sendHdr("R8 class5 unmapped", 3'd5, 2'd0, 2'd3, 3'd0);
    sendHdr("R5 class1 ch1", 3'd1, 2'd0, 2'd0, 3'd1);
    sendHdr("R5 class2 ch1", 3'd2, 2'd0, 2'd0, 3'd1);
    wrCfg(3'd2, 8'hF0, 1'b0);
    // R4 conflict on class 2
    wrCfg(3'd2, 8'h0C, 1'b1);
    rdMap("R4 ch2 map kept", 3'd2, 8'hF0);
    // R3 class0 on another channel
    wrCfg(3'd1, 8'h03, 1'b1);
    rdMap("R3 ch1 map kept", 3'd1, 8'h06);
    // R6 channel 3 disabled (min(3,2)=2)
    wrCfg(3'd3, 8'h08, 1'b1);
    rdMap("R6 ch3 untouched", 3'd3, 8'h00);
    wrCfg(3'd0, 8'h09, 1'b0);
    rdMap("R5 ch0 two classes", 3'd0, 8'h09);
    sendHdr("R1 class3 ch0", 3'd3, 2'd0, 2'd0, 3'd0);
    sendHdr("R1 class7 ch2", 3'd7, 2'd0, 2'd0, 3'd2);
    sendHdr("R1 class4 ch2", 3'd4, 2'd0, 2'd0, 3'd2);
    // R7 class rules by type
    sendHdr("R7 cfg class2", 3'd2, 2'd1, 2'd2, 3'd0);
    sendHdr("R7 io class7", 3'd7, 2'd2, 2'd2, 3'd0);
    sendHdr("R7 msg class0", 3'd0, 2'd3, 2'd0, 3'd0);
    sendHdr("R7 cfg class0", 3'd0, 2'd1, 2'd0, 3'd0);
    // R6 shrink to one channel
    @(negedge clk); peerMaxCnt = 3'd0;
    @(negedge clk);
    rdMap("R6 ch1 cleared", 3'd1, 8'h00);
    sendHdr("R6 class1 unmapped", 3'd1, 2'd0, 2'd3, 3'd0);
    wrCfg(3'd1, 8'h02, 1'b1);
    @(negedge clk); peerMaxCnt = 3'd7; localMaxCnt = 3'd7;
    wrCfg(3'd1, 8'h02, 1'b0);
    wrCfg(3'd7, 8'h04, 1'b0);
    sendHdr("R6 class2 ch7", 3'd2, 2'd0, 2'd0, 3'd7);
    // R10 back-pressure on ch1
    @(negedge clk); outReady[1] = 1'b0;
    sendHdr("R10 class1 into ch1", 3'd1, 2'd0, 2'd0, 3'd1);
    @(negedge clk);
    hdrValid = 1'b1; hdrClass = 3'd1; hdrType = 2'd0; #1;
    check("R10 ch1 full not ready", hdrReady, 0);
    hdrValid = 1'b0;
    sendHdr("R10 class0 passes stall", 3'd0, 2'd0, 2'd0, 3'd0);
    sendHdr("R10 drop while stalled", 3'd6, 2'd1, 2'd2, 3'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R10 stalled hold valid", outValid[1], 1);
      check("R10 stalled hold class", outClass[5:3], 1);
    end
    @(posedge clk); #1 outReady[1] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R10 drained", outValid[1], 0);
    repeat (4) @(negedge clk);
    check("R1 scoreboard empty", expQ.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule